// File: doc/BRIEF.md
# Systolic DNA Local-Alignment Scorer

This block scores the best local alignment between a short query DNA strand and a database strand that streams past it. It uses a Smith-Waterman style recurrence. A row of processing cells holds the query, one base per cell. Database bases enter at the first cell, one per clock, and move one cell per clock toward the last cell. Each cell finishes one matrix entry per cycle, so the array fills as many entries per clock as it has cells.

Each cell carries three values: its own row score, the gap score along the database direction, and the gap score along the query direction, which arrives from the cell before it. The substitution score checks whether the two bases are the same. If they differ, it checks whether they belong to the same chemical class. Gaps use an affine model with separate open and extend costs. Every score is held at or above zero and is clipped at the top of its register width. A collector after the last cell keeps the largest entry of the current database strand. When the final base of that strand leaves the array, the collector presents the result with a one-cycle strobe.

The query is shifted in serially before streaming begins. A strand may contain idle cycles anywhere. A new strand may follow the previous one with no idle cycle between them.

Top module: `sw_align_array`

## Requirements
- R1: Query bases are loaded one per cycle while `q_load` is high. After NUM_PE loads, the k-th base loaded (k from 0) sits in row k, and row 0 is the cell that sees database bases first. Query contents do not change while `q_load` is low.
- R2: Bases are coded A=2'b00, C=2'b01, G=2'b10, T=2'b11. An identical pair adds MATCH (default +10).
- R3: Bit 0 of a base gives its class: 0 for purines (A, G) and 1 for pyrimidines (C, T). A mismatch inside one class scores TRANSI (default -1). A mismatch across classes scores TRANSV (default -5).
- R4: A gap costs GAP_OPEN (default 4) for its first position and GAP_EXT (default 1) for each further position, in both directions.
- R5: Each cell score is max(0, diagonal + substitution, row gap, column gap), so no score is ever below zero. A strand with no positive-scoring pair reports 0.
- R6: A base presented with `db_start` high begins a new strand. All row, gap and running-maximum state acts as zero for that strand, even when it directly follows the previous one.
- R7: Cycles with `db_valid` low are bubbles. They change no state and do not alter the reported score.
- R8: `score_done` is high for one cycle, on the NUM_PE-th rising edge after the edge that sampled the base carrying `db_last`. In that same cycle `max_score` shows the largest cell score of the strand, and it holds that value until the next strobe.
- R9: Every score saturates at 2^SCORE_W-1 instead of wrapping.
- R10: After reset, `score_done` is low and `max_score` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_load | input | 1 | Shift `q_base` into the query chain |
| q_base | input | 2 | Query base to load |
| db_valid | input | 1 | A database base is present this cycle |
| db_start | input | 1 | This base is the first of a strand |
| db_last | input | 1 | This base is the last of a strand |
| db_base | input | 2 | Database base |
| max_score | output | SCORE_W | Best local score of the last finished strand |
| score_done | output | 1 | One-cycle strobe: `max_score` has just been updated |

## Verification
The assertions rely on four conditions on the inputs. The first valid base of every strand carries `db_start`. The final valid base carries `db_last`. `db_start` and `db_last` are only meaningful together with `db_valid`. The query is never reloaded while a strand is still inside the array. The stimulus loads the query only after the array has drained. It always marks the first and last bases of each strand, and it inserts bubbles only between valid bases of one strand, so every cell sees the same ordered list of valid bases.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef logic [1:0] base_t;

  localparam base_t BASE_A = 2'b00;
  localparam base_t BASE_C = 2'b01;
  localparam base_t BASE_G = 2'b10;
  localparam base_t BASE_T = 2'b11;

  // Bit 0 of the code separates purines (0) from pyrimidines (1).
  function automatic logic is_pyrimidine(input base_t b);
    return b[0];
  endfunction

  // Substitution score for a pair of bases.
  function automatic int pair_score(input base_t a, input base_t b,
                                    input int same_sc, input int transi_sc,
                                    input int transv_sc);
    if (a == b)
      return same_sc;
    else if (is_pyrimidine(a) == is_pyrimidine(b))
      return transi_sc;
    else
      return transv_sc;
  endfunction

endpackage

// File: rtl/sw_pe.sv
module sw_pe
  import sw_pkg::*;
#(
  parameter int SCORE_W  = 16,
  parameter int MATCH    = 10,
  parameter int TRANSI   = -1,
  parameter int TRANSV   = -5,
  parameter int GAP_OPEN = 4,
  parameter int GAP_EXT  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               q_load,
  input  base_t              q_shift_in,
  output base_t              q_held,
  input  logic               v_in,
  input  logic               start_in,
  input  logic               last_in,
  input  base_t              b_in,
  input  logic [SCORE_W-1:0] h_in,
  input  logic [SCORE_W-1:0] f_in,
  input  logic [SCORE_W-1:0] m_in,
  output logic               v_out,
  output logic               start_out,
  output logic               last_out,
  output base_t              b_out,
  output logic [SCORE_W-1:0] h_out,
  output logic [SCORE_W-1:0] f_out,
  output logic [SCORE_W-1:0] m_out
);

  localparam int EW = SCORE_W + 2;
  typedef logic signed [EW-1:0] sval_t;
  typedef logic [SCORE_W-1:0]   uval_t;

  localparam sval_t CAP_S   = sval_t'({2'b00, {SCORE_W{1'b1}}});
  localparam sval_t OPEN_S  = sval_t'(GAP_OPEN);
  localparam sval_t EXT_S   = sval_t'(GAP_EXT);
  localparam uval_t MATCH_U = uval_t'(MATCH);
  localparam uval_t ALL_ONE = {SCORE_W{1'b1}};

  function automatic sval_t widen(input uval_t u);
    return sval_t'({2'b00, u});
  endfunction

  function automatic sval_t smax(input sval_t a, input sval_t b);
    return (a > b) ? a : b;
  endfunction

  function automatic uval_t clip(input sval_t v);
    if (v < 0)
      return '0;
    else if (v > CAP_S)
      return ALL_ONE;
    else
      return v[SCORE_W-1:0];
  endfunction

  base_t q_reg;
  uval_t diag_q;   // neighbour score one column back
  uval_t left_q;   // own score one column back
  uval_t eleft_q;  // own row-gap score one column back

  uval_t diag_eff, left_eff, eleft_eff;
  sval_t subst_s;
  uval_t e_new, f_new, h_new, m_new;

  assign q_held = q_reg;

  always_comb begin
    diag_eff  = start_in ? '0 : diag_q;
    left_eff  = start_in ? '0 : left_q;
    eleft_eff = start_in ? '0 : eleft_q;
    subst_s   = sval_t'(pair_score(b_in, q_reg, MATCH, TRANSI, TRANSV));
    e_new     = clip(smax(widen(left_eff) - OPEN_S, widen(eleft_eff) - EXT_S));
    f_new     = clip(smax(widen(h_in) - OPEN_S, widen(f_in) - EXT_S));
    h_new     = clip(smax(smax(widen(diag_eff) + subst_s, '0),
                          smax(widen(e_new), widen(f_new))));
    m_new     = (m_in > h_new) ? m_in : h_new;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_reg <= BASE_A;
    end else if (q_load) begin
      q_reg <= q_shift_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out     <= 1'b0;
      start_out <= 1'b0;
      last_out  <= 1'b0;
      b_out     <= BASE_A;
      h_out     <= '0;
      f_out     <= '0;
      m_out     <= '0;
      diag_q    <= '0;
      left_q    <= '0;
      eleft_q   <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        start_out <= start_in;
        last_out  <= last_in;
        b_out     <= b_in;
        h_out     <= h_new;
        f_out     <= f_new;
        m_out     <= m_new;
        diag_q    <= h_in;
        left_q    <= h_new;
        eleft_q   <= e_new;
      end
    end
  end

  AST_QUERY_HELD: assert property (@(posedge clk) disable iff (rst)
    !q_load |=> $stable(q_reg)); // R1

  AST_MATCH_GAIN: assert property (@(posedge clk) disable iff (rst)
    (v_in && !start_in && (b_in == q_reg) && (diag_q <= ALL_ONE - MATCH_U))
      |=> (h_out >= $past(diag_q) + MATCH_U)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !v_in |=> ($stable(h_out) && $stable(f_out) && $stable(m_out))); // R7

endmodule

// File: rtl/sw_max_collect.sv
module sw_max_collect #(
  parameter int SCORE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               v_in,
  input  logic               start_in,
  input  logic               last_in,
  input  logic [SCORE_W-1:0] col_max,
  output logic [SCORE_W-1:0] best_score,
  output logic               best_done
);

  logic [SCORE_W-1:0] run_q;
  logic [SCORE_W-1:0] run_next;

  always_comb begin
    if (start_in)
      run_next = col_max;
    else
      run_next = (run_q > col_max) ? run_q : col_max;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= '0;
      best_score <= '0;
      best_done  <= 1'b0;
    end else begin
      best_done <= v_in && last_in;
      if (v_in) begin
        run_q <= run_next;
        if (last_in)
          best_score <= run_next;
      end
    end
  end

  AST_RUN_MONOTONE: assert property (@(posedge clk) disable iff (rst)
    (v_in && !start_in) |=> (run_q >= $past(run_q))); // R8

  AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
    best_done |-> $past(v_in && last_in)); // R8

  AST_SCORE_HELD: assert property (@(posedge clk) disable iff (rst)
    !best_done |-> $stable(best_score)); // R8

endmodule

// File: rtl/sw_align_array.sv
module sw_align_array
  import sw_pkg::*;
#(
  parameter int NUM_PE   = 16,
  parameter int SCORE_W  = 16,
  parameter int MATCH    = 10,
  parameter int TRANSI   = -1,
  parameter int TRANSV   = -5,
  parameter int GAP_OPEN = 4,
  parameter int GAP_EXT  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               q_load,
  input  logic [1:0]         q_base,
  input  logic               db_valid,
  input  logic               db_start,
  input  logic               db_last,
  input  logic [1:0]         db_base,
  output logic [SCORE_W-1:0] max_score,
  output logic               score_done
);

  // Link k carries the inputs of cell k; link NUM_PE is the array output.
  logic               lk_v     [NUM_PE+1];
  logic               lk_start [NUM_PE+1];
  logic               lk_last  [NUM_PE+1];
  base_t              lk_b     [NUM_PE+1];
  logic [SCORE_W-1:0] lk_h     [NUM_PE+1];
  logic [SCORE_W-1:0] lk_f     [NUM_PE+1];
  logic [SCORE_W-1:0] lk_m     [NUM_PE+1];
  base_t              q_chain  [NUM_PE];

  assign lk_v[0]     = db_valid;
  assign lk_start[0] = db_start;
  assign lk_last[0]  = db_last;
  assign lk_b[0]     = db_base;
  assign lk_h[0]     = '0;
  assign lk_f[0]     = '0;
  assign lk_m[0]     = '0;

  for (genvar k = 0; k < NUM_PE; k++) begin : g_cell
    base_t q_src;
    if (k == NUM_PE - 1) begin : g_tail
      assign q_src = q_base;
    end else begin : g_mid
      assign q_src = q_chain[k+1];
    end

    sw_pe #(
      .SCORE_W (SCORE_W),
      .MATCH   (MATCH),
      .TRANSI  (TRANSI),
      .TRANSV  (TRANSV),
      .GAP_OPEN(GAP_OPEN),
      .GAP_EXT (GAP_EXT)
    ) u_pe (
      .clk       (clk),
      .rst       (rst),
      .q_load    (q_load),
      .q_shift_in(q_src),
      .q_held    (q_chain[k]),
      .v_in      (lk_v[k]),
      .start_in  (lk_start[k]),
      .last_in   (lk_last[k]),
      .b_in      (lk_b[k]),
      .h_in      (lk_h[k]),
      .f_in      (lk_f[k]),
      .m_in      (lk_m[k]),
      .v_out     (lk_v[k+1]),
      .start_out (lk_start[k+1]),
      .last_out  (lk_last[k+1]),
      .b_out     (lk_b[k+1]),
      .h_out     (lk_h[k+1]),
      .f_out     (lk_f[k+1]),
      .m_out     (lk_m[k+1])
    );
  end

  sw_max_collect #(
    .SCORE_W(SCORE_W)
  ) u_collect (
    .clk       (clk),
    .rst       (rst),
    .v_in      (lk_v[NUM_PE]),
    .start_in  (lk_start[NUM_PE]),
    .last_in   (lk_last[NUM_PE]),
    .col_max   (lk_m[NUM_PE]),
    .best_score(max_score),
    .best_done (score_done)
  );

  AST_DONE_NOT_IN_RESET: assert property (@(posedge clk)
    rst |=> (!score_done && (max_score == '0))); // R10

endmodule

// File: tb/sw_align_array_tb_top.sv
`timescale 1ns/1ps
module sw_align_array_tb_top;

  localparam int N     = 16;
  localparam int W     = 16;
  localparam int SAT_W = 6;
  localparam int CAP16 = (1 << W) - 1;
  localparam int CAP6  = (1 << SAT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic q_load = 1'b0;
  logic [1:0] q_base = 2'b00;
  logic db_valid = 1'b0, db_start = 1'b0, db_last = 1'b0;
  logic [1:0] db_base = 2'b00;
  logic [W-1:0]     score16;
  logic             done16;
  logic [SAT_W-1:0] score6;
  logic             done6;

  always #2 clk = ~clk;

  sw_align_array #(.NUM_PE(N), .SCORE_W(W)) dut_i (
    .clk(clk), .rst(rst), .q_load(q_load), .q_base(q_base),
    .db_valid(db_valid), .db_start(db_start), .db_last(db_last), .db_base(db_base),
    .max_score(score16), .score_done(done16));

  sw_align_array #(.NUM_PE(N), .SCORE_W(SAT_W)) dut_sat_i (
    .clk(clk), .rst(rst), .q_load(q_load), .q_base(q_base),
    .db_valid(db_valid), .db_start(db_start), .db_last(db_last), .db_base(db_base),
    .max_score(score6), .score_done(done6));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 1'b0;
  bit [1:0] qry[N];
  bit [1:0] pat[N] = '{0,1,2,3,3,2,1,0,2,2,0,3,1,1,3,0};
  bit [1:0] dbs[$];
  int sc16_q[$], cy16_q[$], sc6_q[$], cy6_q[$];
  string tg16_q[$];
  int lfsr = 32'h1d2c3b4a;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Independent reference: full local-alignment recurrence, column by column.
  function automatic int model(int cap);
    int hp[N+1];
    int e[N+1];
    int best = 0;
    for (int i = 0; i <= N; i++) begin hp[i] = 0; e[i] = 0; end
    foreach (dbs[j]) begin
      int diag = 0, hup = 0, f = 0;
      for (int i = 1; i <= N; i++) begin
        int t = hp[i];
        int s, h;
        e[i] = imax(0, imax(hp[i] - 4, e[i] - 1));
        f    = imax(0, imax(hup - 4, f - 1));
        if (dbs[j] == qry[i-1]) s = 10;
        else if (dbs[j][0] == qry[i-1][0]) s = -1;
        else s = -5;
        h = imax(0, diag + s);
        h = imax(h, imax(e[i], f));
        if (h > cap) h = cap;
        hp[i] = h; diag = t; hup = h;
        if (h > best) best = h;
      end
    end
    return best;
  endfunction

  function automatic bit [1:0] rnd_base();
    lfsr = (lfsr << 1) ^ ((lfsr < 0) ? 32'h04c11db7 : 0);
    return lfsr[5:4];
  endfunction

  task automatic load_query();
    for (int k = 0; k < N; k++) begin
      @(negedge clk); q_load = 1'b1; q_base = qry[k];
    end
    @(negedge clk); q_load = 1'b0;
  endtask

  // Driver: pushes expected results, then streams the strand.
  task automatic send(string tag, int hand, bit bubbles);
    int e16 = (hand >= 0) ? hand : model(CAP16);
    int e6  = model(CAP6);
    for (int k = 0; k < dbs.size(); k++) begin
      if (bubbles && (k % 2 == 1)) begin
        @(negedge clk); db_valid = 1'b0; db_start = 1'b0; db_last = 1'b0;
      end
      @(negedge clk);
      db_valid = 1'b1; db_base = dbs[k];
      db_start = (k == 0); db_last = (k == dbs.size() - 1);
      if (k == dbs.size() - 1) begin
        sc16_q.push_back(e16); cy16_q.push_back(cyc + 1 + N); tg16_q.push_back(tag);
        sc6_q.push_back(e6);   cy6_q.push_back(cyc + 1 + N);
      end
    end
  endtask

  task automatic idle(int n);
    @(negedge clk); db_valid = 1'b0; db_start = 1'b0; db_last = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares each result strobe with the next expected item.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (done16) begin
        if (sc16_q.size() == 0) check("R8 unexpected strobe", 1, 0);
        else begin
          string t = tg16_q.pop_front();
          check(t, int'(score16), sc16_q.pop_front());
          check("R8 latency", cyc, cy16_q.pop_front());
        end
      end
      if (done6) begin
        if (sc6_q.size() == 0) check("R9 unexpected strobe", 1, 0);
        else begin
          check("R9 saturated score", int'(score6), sc6_q.pop_front());
          check("R8 latency sat", cyc, cy6_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 done in reset", int'(done16), 0);
    check("R10 score in reset", int'(score16), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 done after reset", int'(done16), 0);
    check("R10 score after reset", int'(score16), 0);

    foreach (qry[k]) qry[k] = pat[k];
    load_query();

    // R2 exact copy: 16 matches
    dbs.delete(); foreach (pat[k]) dbs.push_back(pat[k]);
    send("R2 exact copy", 160, 1'b0); idle(N + 4);

    // R3 same-class mismatch in the middle: 15*10-1
    dbs[8] = pat[8] ^ 2'b10;
    send("R3 transition", 149, 1'b0); idle(N + 4);
    // R3 cross-class mismatch: 15*10-5
    dbs[8] = pat[8] ^ 2'b01;
    send("R3 transversion", 145, 1'b0); idle(N + 4);

    // R4 single deletion: 15 matches, gap open 4
    dbs.delete(); foreach (pat[k]) if (k != 8) dbs.push_back(pat[k]);
    send("R4 gap open", 146, 1'b0); idle(N + 4);
    // R4 three deletions: 13 matches, 4+1+1
    dbs.delete(); foreach (pat[k]) if (k < 8 || k > 10) dbs.push_back(pat[k]);
    send("R4 gap extend", 124, 1'b0); idle(N + 4);

    // R5 nothing positive: query all A, strand all C
    foreach (qry[k]) qry[k] = 2'b00;
    load_query();
    dbs.delete(); repeat (20) dbs.push_back(2'b01);
    send("R5 floor at zero", 0, 1'b0); idle(N + 4);

    // R1 load order: reversed query against forward strand
    foreach (qry[k]) qry[k] = pat[N-1-k];
    load_query();
    dbs.delete(); foreach (pat[k]) dbs.push_back(pat[k]);
    send("R1 load order", -1, 1'b0); idle(N + 4);

    foreach (qry[k]) qry[k] = pat[k];
    load_query();

    // R6 back-to-back strands, no idle between them
    dbs.delete(); foreach (pat[k]) dbs.push_back(pat[k]);
    send("R6 first strand", 160, 1'b0);
    dbs.delete(); repeat (12) dbs.push_back(rnd_base());
    send("R6 second strand", -1, 1'b0);
    dbs.delete(); dbs.push_back(pat[0]);
    send("R6 single base", 10, 1'b0); idle(N + 4);

    // R7 bubbles between valid bases
    dbs.delete(); foreach (pat[k]) dbs.push_back(pat[k]);
    dbs[8] = pat[8] ^ 2'b10;
    send("R7 bubbles", 149, 1'b1); idle(N + 4);

    // R2 random strands against the reference model
    for (int r = 0; r < 3; r++) begin
      dbs.delete(); repeat (30) dbs.push_back(rnd_base());
      send("R2 random strand", -1, 1'b0);
    end
    idle(N + 8);

    check("R8 all results seen", sc16_q.size() + sc6_q.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule